// File: doc/BRIEF.md
# Cascaded Local/Mapped Interrupt Controller

This block collects level-sensitive interrupt requests into two local groups of eight sources each. Each local group has a live status view and a mask register, and drives one CPU interrupt line. A third group of eight sources, called the mapped group, has one shared status view and two independent mask registers. Each masked mapped group folds into a single fixed bit of a local group: map mask 0 feeds local0 bit 7, and map mask 1 feeds local1 bit 3. Software then sees a mapped event as one local source, and finds the actual mapped source by reading the mapped status.

The block also holds two timer interrupt latches. A latch sets on the rising edge of its timer pulse. Software clears one or both latches with a write-one-to-clear register. All registers sit on a simple 32-bit bus. A write takes effect at the next clock edge. A read returns data combinationally from the word address.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A read at offset 0x00 returns the local0 status. Bits 6:0 follow local0Src live. Bit 7 is the OR of (mapSrc AND map mask 0). The level on local0Src[7] is ignored.
- R2: A read at offset 0x08 returns the local1 status. Every bit except bit 3 follows local1Src live. Bit 3 is the OR of (mapSrc AND map mask 1). The level on local1Src[3] is ignored.
- R3: cpuIrq0 is high exactly when (local0 status AND local0 mask) is nonzero. cpuIrq1 is high exactly when (local1 status AND local1 mask) is nonzero.
- R4: The mask registers sit at these offsets: local0 mask at 0x04, local1 mask at 0x0C, map mask 0 at 0x14 and map mask 1 at 0x18. Each stores bits 7:0 of a write and reads back the value last written. All four reset to zero.
- R5: A read at offset 0x10 returns the live level of mapSrc.
- R6: A timer latch sets in the cycle after a rising edge on timerPulse[n], and timerIrq[n] shows it. A pulse that stays high after a clear does not set the latch again.
- R7: A write at offset 0x1C clears timer latch n for each set bit n of the write data, so 0x03 clears both latches. A read at offset 0x1C returns the latch states in bits 1:0. Both latches reset to cleared.
- R8: If a rising edge and a clear of the same latch fall in one cycle, the latch ends up set.
- R9: Writes to the status offsets 0x00, 0x08 and 0x10 change no register and no status view.
- R10: Reads of undefined offsets (0x20 to 0x3C) return zero. Bits 31:8 of every read are zero. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| local0Src | input | 8 | Level sources of local group 0 |
| local1Src | input | 8 | Level sources of local group 1 |
| mapSrc | input | 8 | Level sources of the mapped group |
| timerPulse | input | 2 | Timer request pulses, latched on a rising edge |
| cpuIrq0 | output | 1 | CPU interrupt from local group 0 |
| cpuIrq1 | output | 1 | CPU interrupt from local group 1 |
| timerIrq | output | 2 | Timer interrupt latch states |

## Verification
The bench builds the block with its defaults: eight sources per group, two timers, a 6-bit address, and cascade bits 7 and 3. With these values every source bit and every mask bit can be set on the ports. The address also reaches a band of undefined offsets above the eight defined registers, so the zero-read rule can be tested. Because the cascade bits are the defaults, the bench can drive the overridden local source bits directly and see at the status reads that they are ignored.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  localparam int NUM_MASKS = 4;
  localparam int MASK_L0   = 0;
  localparam int MASK_L1   = 1;
  localparam int MASK_MAP0 = 2;
  localparam int MASK_MAP1 = 3;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_L0STAT,
    RD_L0MASK,
    RD_L1STAT,
    RD_L1MASK,
    RD_MAPSTAT,
    RD_MAPMASK0,
    RD_MAPMASK1,
    RD_TIMER
  } rdSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic [NUM_MASKS-1:0] maskWr;
    logic                 timerClrWr;
    rdSel_e               rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_cascade_decode.sv
module irq_cascade_decode
  import irq_cascade_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobe_t        strobe
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              unusedAddrLo;

  assign wordIdx      = busAddr[ADDR_W-1:2];
  assign unusedAddrLo = ^busAddr[1:0];

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    case (wordIdx)
      WORD_W'(0): strobe.rdSel = RD_L0STAT;
      WORD_W'(1): begin
        strobe.rdSel = RD_L0MASK;
        strobe.maskWr[MASK_L0] = busWrEn;
      end
      WORD_W'(2): strobe.rdSel = RD_L1STAT;
      WORD_W'(3): begin
        strobe.rdSel = RD_L1MASK;
        strobe.maskWr[MASK_L1] = busWrEn;
      end
      WORD_W'(4): strobe.rdSel = RD_MAPSTAT;
      WORD_W'(5): begin
        strobe.rdSel = RD_MAPMASK0;
        strobe.maskWr[MASK_MAP0] = busWrEn;
      end
      WORD_W'(6): begin
        strobe.rdSel = RD_MAPMASK1;
        strobe.maskWr[MASK_MAP1] = busWrEn;
      end
      WORD_W'(7): begin
        strobe.rdSel = RD_TIMER;
        strobe.timerClrWr = busWrEn;
      end
      default: strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irq_cascade_datapath.sv
module irq_cascade_datapath
  import irq_cascade_pkg::*;
#(
  parameter int GROUP_W  = 8,
  parameter int DATA_W   = 32,
  parameter int TIMER_N  = 2,
  parameter int MAP0_BIT = 7,
  parameter int MAP1_BIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [GROUP_W-1:0] wrData,
  input  logic [GROUP_W-1:0] local0Src,
  input  logic [GROUP_W-1:0] local1Src,
  input  logic [GROUP_W-1:0] mapSrc,
  input  logic [TIMER_N-1:0] timerPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic               cpuIrq0,
  output logic               cpuIrq1,
  output logic [TIMER_N-1:0] timerIrq
);
  logic [GROUP_W-1:0] maskQ [NUM_MASKS];
  logic [GROUP_W-1:0] l0Stat;
  logic [GROUP_W-1:0] l1Stat;
  logic               map0Hit;
  logic               map1Hit;
  logic [TIMER_N-1:0] pulseQ;
  logic [TIMER_N-1:0] latchQ;

  for (genvar g = 0; g < NUM_MASKS; g++) begin : gMask
    always_ff @(posedge clk) begin
      if (!rstN)                 maskQ[g] <= '0;
      else if (strobe.maskWr[g]) maskQ[g] <= wrData;
    end
  end

  assign map0Hit = |(mapSrc & maskQ[MASK_MAP0]);
  assign map1Hit = |(mapSrc & maskQ[MASK_MAP1]);

  always_comb begin
    l0Stat = local0Src;
    l0Stat[MAP0_BIT] = map0Hit;
    l1Stat = local1Src;
    l1Stat[MAP1_BIT] = map1Hit;
  end

  assign cpuIrq0 = |(l0Stat & maskQ[MASK_L0]);
  assign cpuIrq1 = |(l1Stat & maskQ[MASK_L1]);

  for (genvar t = 0; t < TIMER_N; t++) begin : gTimer
    logic riseNow;
    logic clrNow;
    assign riseNow = timerPulse[t] & ~pulseQ[t];
    assign clrNow  = strobe.timerClrWr & wrData[t];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pulseQ[t] <= 1'b0;
        latchQ[t] <= 1'b0;
      end else begin
        pulseQ[t] <= timerPulse[t];
        latchQ[t] <= riseNow | (latchQ[t] & ~clrNow);
      end
    end
  end

  assign timerIrq = latchQ;

  always_comb begin
    case (strobe.rdSel)
      RD_L0STAT:   rdData = DATA_W'(l0Stat);
      RD_L0MASK:   rdData = DATA_W'(maskQ[MASK_L0]);
      RD_L1STAT:   rdData = DATA_W'(l1Stat);
      RD_L1MASK:   rdData = DATA_W'(maskQ[MASK_L1]);
      RD_MAPSTAT:  rdData = DATA_W'(mapSrc);
      RD_MAPMASK0: rdData = DATA_W'(maskQ[MASK_MAP0]);
      RD_MAPMASK1: rdData = DATA_W'(maskQ[MASK_MAP1]);
      RD_TIMER:    rdData = DATA_W'(latchQ);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int GROUP_W  = 8,
  parameter int TIMER_N  = 2,
  parameter int MAP0_BIT = 7,
  parameter int MAP1_BIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [GROUP_W-1:0] local0Src,
  input  logic [GROUP_W-1:0] local1Src,
  input  logic [GROUP_W-1:0] mapSrc,
  input  logic [TIMER_N-1:0] timerPulse,
  output logic               cpuIrq0,
  output logic               cpuIrq1,
  output logic [TIMER_N-1:0] timerIrq
);
  ctlStrobe_t strobe;
  logic       unusedWrHi;

  assign unusedWrHi = ^busWrData[DATA_W-1:GROUP_W];

  irq_cascade_decode #(.ADDR_W(ADDR_W)) decode_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  irq_cascade_datapath #(
    .GROUP_W (GROUP_W),
    .DATA_W  (DATA_W),
    .TIMER_N (TIMER_N),
    .MAP0_BIT(MAP0_BIT),
    .MAP1_BIT(MAP1_BIT)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData[GROUP_W-1:0]),
    .local0Src (local0Src),
    .local1Src (local1Src),
    .mapSrc    (mapSrc),
    .timerPulse(timerPulse),
    .rdData    (busRdData),
    .cpuIrq0   (cpuIrq0),
    .cpuIrq1   (cpuIrq1),
    .timerIrq  (timerIrq)
  );
endmodule

// File: rtl/irq_cascade_ctrl_chk.sv
module irq_cascade_ctrl_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int GROUP_W  = 8,
  parameter int TIMER_N  = 2,
  parameter int MAP0_BIT = 7,
  parameter int MAP1_BIT = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-3:0]  wordIdx,
  input logic               busWrEn,
  input logic [GROUP_W-1:0] wrLow,
  input logic [DATA_W-1:0]  busRdData,
  input logic [GROUP_W-1:0] local0Src,
  input logic [GROUP_W-1:0] local1Src,
  input logic [GROUP_W-1:0] mapSrc,
  input logic [TIMER_N-1:0] timerPulse,
  input logic               cpuIrq0,
  input logic               cpuIrq1,
  input logic [TIMER_N-1:0] timerIrq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [GROUP_W-1:0] shL0, shL1, shM0, shM1;
  logic [GROUP_W-1:0] predL0, predL1;
  logic               clrWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shL0 <= '0; shL1 <= '0; shM0 <= '0; shM1 <= '0;
    end else if (busWrEn) begin
      if (wordIdx == WORD_W'(1)) shL0 <= wrLow;
      if (wordIdx == WORD_W'(3)) shL1 <= wrLow;
      if (wordIdx == WORD_W'(5)) shM0 <= wrLow;
      if (wordIdx == WORD_W'(6)) shM1 <= wrLow;
    end
  end

  always_comb begin
    for (int i = 0; i < GROUP_W; i++) begin
      predL0[i] = (i == MAP0_BIT) ? |(mapSrc & shM0) : local0Src[i];
      predL1[i] = (i == MAP1_BIT) ? |(mapSrc & shM1) : local1Src[i];
    end
  end

  assign clrWrite = busWrEn && (wordIdx == WORD_W'(7));

  // R3
  p_local0_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq0 == |(predL0 & shL0));
  // R3
  p_local1_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq1 == |(predL1 & shL1));
  // R10
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:GROUP_W] == '0);

  for (genvar t = 0; t < TIMER_N; t++) begin : gTimerChk
    // R6 and R8: a rising edge sets the latch even under a clear
    p_timer_set_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(timerPulse[t]) |=> timerIrq[t]);
    // R7
    p_timer_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
      (clrWrite && wrLow[t] && !timerPulse[t]) |=> !timerIrq[t]);
    // R6: latch holds until cleared
    p_timer_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (timerIrq[t] && !(clrWrite && wrLow[t])) |=> timerIrq[t]);
  end
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .GROUP_W (GROUP_W),
  .TIMER_N (TIMER_N),
  .MAP0_BIT(MAP0_BIT),
  .MAP1_BIT(MAP1_BIT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wordIdx   (busAddr[ADDR_W-1:2]),
  .busWrEn   (busWrEn),
  .wrLow     (busWrData[GROUP_W-1:0]),
  .busRdData (busRdData),
  .local0Src (local0Src),
  .local1Src (local1Src),
  .mapSrc    (mapSrc),
  .timerPulse(timerPulse),
  .cpuIrq0   (cpuIrq0),
  .cpuIrq1   (cpuIrq1),
  .timerIrq  (timerIrq)
);

// File: tb/irq_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [7:0]  local0Src, local1Src, mapSrc;
  logic [1:0]  timerPulse;
  logic        cpuIrq0, cpuIrq1;
  logic [1:0]  timerIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .local0Src(local0Src), .local1Src(local1Src), .mapSrc(mapSrc),
    .timerPulse(timerPulse), .cpuIrq0(cpuIrq0), .cpuIrq1(cpuIrq1),
    .timerIrq(timerIrq)
  );

  typedef struct packed {
    logic [7:0] l0, l1, mp, k0, k1, q0, q1;
    logic [7:0] s0, s1;
    logic       e0, e1;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0},
    '{8'h01, 8'h10, 8'h00, 8'hFE, 8'h10, 8'h00, 8'h00, 8'h01, 8'h10, 1'b0, 1'b1},
    '{8'h80, 8'h00, 8'h04, 8'h80, 8'h00, 8'h04, 8'h00, 8'h80, 8'h00, 1'b1, 1'b0},
    '{8'h00, 8'h00, 8'h04, 8'hFF, 8'h08, 8'h00, 8'h04, 8'h00, 8'h08, 1'b0, 1'b1},
    '{8'h7F, 8'h08, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h7F, 8'h00, 1'b0, 1'b0},
    '{8'h00, 8'h00, 8'hF0, 8'h80, 8'h08, 8'h0F, 8'hF0, 8'h00, 8'h08, 1'b0, 1'b1},
    '{8'h80, 8'h00, 8'hFF, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busWrData = '0;
    local0Src = '0; local1Src = '0; mapSrc = '0; timerPulse = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state: R4, R7, R3
    local0Src = 8'hFF; local1Src = 8'hFF; mapSrc = 8'hFF;
    #1;
    check("R3 reset irq0", {31'd0, cpuIrq0}, 32'd0);
    check("R3 reset irq1", {31'd0, cpuIrq1}, 32'd0);
    check("R7 reset timerIrq", {30'd0, timerIrq}, 32'd0);
    for (int a = 1; a < 8; a += 2) begin
      if (a == 7) continue;
      busRead(6'(a * 4), rd);
      check("R4 reset mask", rd, 32'd0);
    end
    busRead(6'h14, rd); check("R4 reset map mask 0", rd, 32'd0);
    busRead(6'h1C, rd); check("R7 reset latch read", rd, 32'd0);
    @(negedge clk);

    // table-driven: R1 R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      busWrite(6'h04, {24'd0, VECS[v].k0});
      busWrite(6'h0C, {24'd0, VECS[v].k1});
      busWrite(6'h14, {24'd0, VECS[v].q0});
      busWrite(6'h18, {24'd0, VECS[v].q1});
      local0Src = VECS[v].l0; local1Src = VECS[v].l1; mapSrc = VECS[v].mp;
      busRead(6'h00, rd); check("R1 local0 status", rd, {24'd0, VECS[v].s0});
      busRead(6'h08, rd); check("R2 local1 status", rd, {24'd0, VECS[v].s1});
      busRead(6'h10, rd); check("R5 map status", rd, {24'd0, VECS[v].mp});
      busRead(6'h04, rd); check("R4 local0 mask readback", rd, {24'd0, VECS[v].k0});
      busRead(6'h18, rd); check("R4 map mask 1 readback", rd, {24'd0, VECS[v].q1});
      check("R3 cpuIrq0", {31'd0, cpuIrq0}, {31'd0, VECS[v].e0});
      check("R3 cpuIrq1", {31'd0, cpuIrq1}, {31'd0, VECS[v].e1});
      @(negedge clk);
    end

    // R9: writes to status offsets change nothing (last vector state)
    busWrite(6'h00, 32'hFFFF_FFFF);
    busWrite(6'h08, 32'hFFFF_FFFF);
    busWrite(6'h10, 32'hFFFF_FFFF);
    busRead(6'h04, rd); check("R9 local0 mask kept", rd, 32'h80);
    busRead(6'h0C, rd); check("R9 local1 mask kept", rd, 32'h00);
    busRead(6'h00, rd); check("R9 local0 status kept", rd, 32'h00);
    busRead(6'h10, rd); check("R9 map status kept", rd, 32'hFF);
    @(negedge clk);

    // R10: undefined offsets, upper bits, low address bits
    busRead(6'h20, rd); check("R10 undefined 0x20", rd, 32'd0);
    busRead(6'h3C, rd); check("R10 undefined 0x3C", rd, 32'd0);
    @(negedge clk);
    busWrite(6'h14, 32'hFFFF_FFFF);
    busRead(6'h14, rd); check("R10 upper bits zero", rd, 32'h0000_00FF);
    busRead(6'h17, rd); check("R10 low address bits ignored", rd, 32'h0000_00FF);
    @(negedge clk);

    // R6: rising edge sets latch one cycle later
    timerPulse = 2'b01;
    @(negedge clk);
    check("R6 timer0 set", {30'd0, timerIrq}, 32'h1);
    busRead(6'h1C, rd); check("R7 latch readback", rd, 32'h1);
    @(negedge clk);
    busWrite(6'h1C, 32'h1);
    check("R6 held level no reset", {30'd0, timerIrq}, 32'h0);
    @(negedge clk);
    check("R6 held level stays clear", {30'd0, timerIrq}, 32'h0);

    // R7: selective and combined clear
    timerPulse = 2'b00;
    @(negedge clk);
    timerPulse = 2'b11;
    @(negedge clk);
    check("R6 both set", {30'd0, timerIrq}, 32'h3);
    busWrite(6'h1C, 32'h1);
    check("R7 clear bit0 only", {30'd0, timerIrq}, 32'h2);
    timerPulse = 2'b00;
    @(negedge clk);
    timerPulse = 2'b01;
    @(negedge clk);
    check("R7 timer0 set again", {30'd0, timerIrq}, 32'h3);
    busWrite(6'h1C, 32'h3);
    check("R7 clear both", {30'd0, timerIrq}, 32'h0);

    // R8: set and clear in the same cycle
    timerPulse = 2'b00;
    @(negedge clk);
    busAddr = 6'h1C; busWrData = 32'h3; busWrEn = 1'b1; timerPulse = 2'b01;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R8 set wins over clear", {30'd0, timerIrq}, 32'h1);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule